// File: doc/BRIEF.md
# OLED Power-Up and Sleep Sequencer

This block brings a monochrome OLED panel controller out of hardware reset and then moves it between an active state and a low-power sleep state. All of its traffic to the controller is a stream of bytes, each marked as a command, over a simple valid/ready write port. The physical bus timing is left to a downstream bus engine, and so is the pixel transfer.

After a start strobe the sequencer holds the panel reset line low. It then releases the line, waits for the controller to recover, and plays a constant table of 25 configuration bytes. Some of these are single-byte commands and some are commands followed by operand bytes. Next it enables the panel high-voltage supply and waits for it to settle. It issues display-on and asks a downstream refresh engine for one full-frame refresh, so that panel RAM matches a cleared framebuffer. The block reports done only after that request is acknowledged.

Once initialised, a sleep request sends display-off, waits, and removes the high voltage. A wake request restores the high voltage, waits, and sends display-on again without a new refresh. All waits are whole milliseconds. The millisecond tick comes from a cycle counter whose length is a parameter derived from the clock frequency.

States and transitions:
- `S_IDLE` goes to `S_RST_HOLD` on start.
- `S_RST_HOLD` goes to `S_RST_WAIT` when its timer expires.
- `S_RST_WAIT` goes to `S_INIT_CMD` when its timer expires.
- `S_INIT_CMD` goes to `S_WAKE_HV` once the last table byte is accepted.
- `S_WAKE_HV` goes to `S_WAKE_CMD` when its timer expires.
- `S_WAKE_CMD` goes to `S_REFRESH` on acceptance during the first power-up, and to `S_READY` on later wakes.
- `S_REFRESH` goes to `S_READY` on acknowledge.
- `S_READY` goes to `S_SLEEP_CMD` on a sleep request.
- `S_SLEEP_CMD` goes to `S_SLEEP_WAIT` on acceptance.
- `S_SLEEP_WAIT` goes to `S_ASLEEP` when its timer expires.
- `S_ASLEEP` goes to `S_WAKE_HV` on a wake request.

Top module: `oled_pwr_seq`

## Requirements
- R1: Out of system reset, the panel reset output is low (asserted), the high-voltage enable is 0, no byte is offered (write valid 0), and both busy and done are 0.
- R2: After a start strobe, the panel reset output stays low for at least HOLD_MS milliseconds (HOLD_MS × MS_CYCLES clock cycles, default 10 ms) and then goes high. No byte is offered while it is low.
- R3: After the panel reset output goes high, no byte is accepted for at least RECOV_MS milliseconds (default 120 ms).
- R4: The init table goes out in this exact order: AE, D5, 50, 20, 81, 8F, AD, 8A, A1, C8, DC, 00, D3, 00, D9, 22, DB, 35, A8, 7F, B0, 00, 10, A4, A6 (hex). Every byte the block emits has the command flag at 1.
- R5: While write valid is high and write ready is low, valid stays high and the byte is held stable. A byte counts as sent only on a clock edge where valid and ready are both high.
- R6: After the table, the high-voltage enable goes to 1. The display-on byte AF is accepted no earlier than HV_MS milliseconds later (default 100 ms).
- R7: After AF during power-up, the refresh request goes high and is held until the refresh acknowledge. Done rises only after the acknowledge and then stays high, and busy returns to 0.
- R8: A sleep request while ready and idle sends AE. The high-voltage enable then goes to 0 no earlier than SLEEP_MS milliseconds (default 5 ms) after AE is accepted.
- R9: A wake request while asleep raises the high-voltage enable and sends AF after HV_MS milliseconds. It then returns to the ready state with no further refresh request.
- R10: Sleep and wake requests are ignored before initialisation completes. A start strobe has no effect once the sequence has begun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start_i | input | 1 | Start strobe; begins power-up from idle |
| sleep_req_i | input | 1 | Sleep request, honoured in ready state |
| wake_req_i | input | 1 | Wake request, honoured in asleep state |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Power-up completed, refresh acknowledged |
| wr_valid_o | output | 1 | A byte is offered on the write port |
| wr_ready_i | input | 1 | Write port accepts the offered byte |
| wr_cmd_o | output | 1 | Command (1) / data (0) flag of the byte |
| wr_byte_o | output | 8 | Byte offered on the write port |
| panel_rst_n_o | output | 1 | Panel reset line, active low |
| hv_en_o | output | 1 | Panel high-voltage supply enable |
| refresh_req_o | output | 1 | Request for one full-frame refresh |
| refresh_ack_i | input | 1 | Refresh engine acknowledge |

## Verification
The full power-up, sleep and wake cycle is run four times, once for each write-port stall length from zero to three idle cycles per byte. This separates correct holding and ordering of bytes under back-pressure from a design that only works when ready is always high. Each wait is measured in cycles against both a lower and an upper arithmetic bound derived from the shrunken millisecond length. This catches a shortened wait as well as an extra or missing millisecond. Sleep, wake and repeated start pulses are injected while idle, mid-initialisation and after completion, so that a request honoured in the wrong state shows up as extra bytes or an early supply change.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_HOLD,
        S_RST_WAIT,
        S_INIT_CMD,
        S_WAKE_HV,
        S_WAKE_CMD,
        S_REFRESH,
        S_READY,
        S_SLEEP_CMD,
        S_SLEEP_WAIT,
        S_ASLEEP
    } seq_state_t;

    localparam int INIT_LEN   = 25;
    localparam int INIT_IDX_W = $clog2(INIT_LEN);

    localparam logic [7:0] CMD_DISP_ON  = 8'hAF;
    localparam logic [7:0] CMD_DISP_OFF = 8'hAE;

    // Configuration bytes, commands with their operands in emission order.
    function automatic logic [7:0] init_byte(input logic [INIT_IDX_W-1:0] i);
        logic [7:0] b;
        unique case (i)
            5'd0:  b = 8'hAE;
            5'd1:  b = 8'hD5;
            5'd2:  b = 8'h50;
            5'd3:  b = 8'h20;
            5'd4:  b = 8'h81;
            5'd5:  b = 8'h8F;
            5'd6:  b = 8'hAD;
            5'd7:  b = 8'h8A;
            5'd8:  b = 8'hA1;
            5'd9:  b = 8'hC8;
            5'd10: b = 8'hDC;
            5'd11: b = 8'h00;
            5'd12: b = 8'hD3;
            5'd13: b = 8'h00;
            5'd14: b = 8'hD9;
            5'd15: b = 8'h22;
            5'd16: b = 8'hDB;
            5'd17: b = 8'h35;
            5'd18: b = 8'hA8;
            5'd19: b = 8'h7F;
            5'd20: b = 8'hB0;
            5'd21: b = 8'h00;
            5'd22: b = 8'h10;
            5'd23: b = 8'hA4;
            5'd24: b = 8'hA6;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/oled_ms_timer.sv
module oled_ms_timer #(
    parameter int MS_CYCLES = 100_000,
    parameter int MS_W      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [MS_W-1:0] ms_i,
    output logic            expired_o
);
    localparam int CYC_W = $clog2(MS_CYCLES + 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(MS_CYCLES - 1);

    logic [CYC_W-1:0] cyc_q;
    logic [MS_W-1:0]  ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            ms_q  <= '0;
        end else if (load_i) begin
            cyc_q <= CYC_LAST;
            ms_q  <= ms_i;
        end else if (ms_q != '0) begin
            if (cyc_q == '0) begin
                cyc_q <= CYC_LAST;
                ms_q  <= ms_q - 1'b1;
            end else begin
                cyc_q <= cyc_q - 1'b1;
            end
        end
    end

    assign expired_o = (ms_q == '0);

    // Once expired, the count stays at zero until reloaded (R2, R3 timing base)
    assert_expired_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/oled_init_rom.sv
module oled_init_rom
    import oled_seq_pkg::*;
(
    input  logic [INIT_IDX_W-1:0] idx_i,
    output logic [7:0]            byte_o
);
    assign byte_o = init_byte(idx_i);
endmodule

// File: rtl/oled_pwr_seq.sv
module oled_pwr_seq
    import oled_seq_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int MS_CYCLES = CLK_HZ / 1000,
    parameter int HOLD_MS   = 10,
    parameter int RECOV_MS  = 120,
    parameter int HV_MS     = 100,
    parameter int SLEEP_MS  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       sleep_req_i,
    input  logic       wake_req_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       wr_valid_o,
    input  logic       wr_ready_i,
    output logic       wr_cmd_o,
    output logic [7:0] wr_byte_o,
    output logic       panel_rst_n_o,
    output logic       hv_en_o,
    output logic       refresh_req_o,
    input  logic       refresh_ack_i
);
    localparam int MAX_AB = (HOLD_MS > RECOV_MS) ? HOLD_MS : RECOV_MS;
    localparam int MAX_CD = (HV_MS > SLEEP_MS) ? HV_MS : SLEEP_MS;
    localparam int MAX_MS = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int MS_W   = $clog2(MAX_MS + 1);
    localparam logic [INIT_IDX_W-1:0] IDX_LAST = INIT_IDX_W'(INIT_LEN - 1);

    seq_state_t state_q, state_d;
    logic [INIT_IDX_W-1:0] idx_q;
    logic [7:0]            rom_byte;
    logic [MS_W-1:0]       ms_sel;
    logic                  tmr_load, tmr_exp;
    logic                  accepted;

    oled_init_rom i_rom (.idx_i(idx_q), .byte_o(rom_byte));

    oled_ms_timer #(.MS_CYCLES(MS_CYCLES), .MS_W(MS_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .ms_i(ms_sel), .expired_o(tmr_exp)
    );

    assign accepted = wr_valid_o && wr_ready_i;
    assign tmr_load = (state_d != state_q);

    // Wait length picked by the state being entered
    always_comb begin
        unique case (state_d)
            S_RST_HOLD:   ms_sel = MS_W'(HOLD_MS);
            S_RST_WAIT:   ms_sel = MS_W'(RECOV_MS);
            S_WAKE_HV:    ms_sel = MS_W'(HV_MS);
            S_SLEEP_WAIT: ms_sel = MS_W'(SLEEP_MS);
            default:      ms_sel = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (start_i) state_d = S_RST_HOLD;
            S_RST_HOLD:   if (tmr_exp) state_d = S_RST_WAIT;
            S_RST_WAIT:   if (tmr_exp) state_d = S_INIT_CMD;
            S_INIT_CMD:   if (accepted && idx_q == IDX_LAST) state_d = S_WAKE_HV;
            S_WAKE_HV:    if (tmr_exp) state_d = S_WAKE_CMD;
            S_WAKE_CMD:   if (accepted) state_d = done_o ? S_READY : S_REFRESH;
            S_REFRESH:    if (refresh_ack_i) state_d = S_READY;
            S_READY:      if (sleep_req_i) state_d = S_SLEEP_CMD;
            S_SLEEP_CMD:  if (accepted) state_d = S_SLEEP_WAIT;
            S_SLEEP_WAIT: if (tmr_exp) state_d = S_ASLEEP;
            S_ASLEEP:     if (wake_req_i) state_d = S_WAKE_HV;
            default:      state_d = S_IDLE;
        endcase
    end

    // State register with registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= S_IDLE;
            idx_q         <= '0;
            panel_rst_n_o <= 1'b0;
            hv_en_o       <= 1'b0;
            done_o        <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_INIT_CMD && accepted) idx_q <= idx_q + 1'b1;
            panel_rst_n_o <= !(state_d == S_IDLE || state_d == S_RST_HOLD);
            hv_en_o <= (state_d == S_WAKE_HV)   || (state_d == S_WAKE_CMD) ||
                       (state_d == S_REFRESH)   || (state_d == S_READY)    ||
                       (state_d == S_SLEEP_CMD) || (state_d == S_SLEEP_WAIT);
            if (state_q == S_REFRESH && refresh_ack_i) done_o <= 1'b1;
        end
    end

    // Output decode
    always_comb begin
        wr_valid_o    = 1'b0;
        wr_byte_o     = 8'h00;
        refresh_req_o = 1'b0;
        busy_o        = 1'b1;
        unique case (state_q)
            S_INIT_CMD:  begin wr_valid_o = 1'b1; wr_byte_o = rom_byte; end
            S_WAKE_CMD:  begin wr_valid_o = 1'b1; wr_byte_o = CMD_DISP_ON; end
            S_SLEEP_CMD: begin wr_valid_o = 1'b1; wr_byte_o = CMD_DISP_OFF; end
            S_REFRESH:   refresh_req_o = 1'b1;
            S_IDLE, S_READY, S_ASLEEP: busy_o = 1'b0;
            default: ;
        endcase
        wr_cmd_o = wr_valid_o;
    end

    assert_no_byte_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n_o |-> !wr_valid_o);

    assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_byte_o)));

    assert_cmd_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> wr_cmd_o);

    assert_on_needs_hv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_byte_o == CMD_DISP_ON) |-> hv_en_o);

    assert_refresh_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req_o && !refresh_ack_i) |=> refresh_req_o);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    assert_no_refresh_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !refresh_req_o);

endmodule

// File: tb/test_oled_pwr_seq.sv
module test_oled_pwr_seq;
    localparam int MS = 4;
    localparam int HOLD = 10, RECOV = 120, HV = 100, SLP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, sleep_req_i = 0, wake_req_i = 0;
    logic busy_o, done_o, wr_valid_o, wr_cmd_o, panel_rst_n_o, hv_en_o, refresh_req_o;
    logic wr_ready_i = 0, refresh_ack_i = 0;
    logic [7:0] wr_byte_o;

    oled_pwr_seq #(.CLK_HZ(4000), .MS_CYCLES(MS), .HOLD_MS(HOLD), .RECOV_MS(RECOV),
                   .HV_MS(HV), .SLEEP_MS(SLP)) i_oled_pwr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sleep_req_i(sleep_req_i),
        .wake_req_i(wake_req_i), .busy_o(busy_o), .done_o(done_o),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_cmd_o(wr_cmd_o),
        .wr_byte_o(wr_byte_o), .panel_rst_n_o(panel_rst_n_o), .hv_en_o(hv_en_o),
        .refresh_req_o(refresh_req_o), .refresh_ack_i(refresh_ack_i));

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] exp_tab [25] = '{8'hAE, 8'hD5, 8'h50, 8'h20, 8'h81, 8'h8F, 8'hAD, 8'h8A,
        8'hA1, 8'hC8, 8'hDC, 8'h00, 8'hD3, 8'h00, 8'hD9, 8'h22, 8'hDB, 8'h35, 8'hA8,
        8'h7F, 8'hB0, 8'h00, 8'h10, 8'hA4, 8'hA6};

    logic [7:0] log_b [64];
    logic       log_c [64];
    int         log_t [64];
    int log_cnt, stall_len, stall_cnt, rst_rise, hv_rise, hv_fall, rq_cnt, ref_count;
    bit prev_stall, rst_seen, hv_prev;
    logic [7:0] prev_byte;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write-port sink, refresh engine model and edge recorder
    always @(negedge clk) begin
        if (rst_n) begin
            bit rdy;
            if (prev_stall)
                chk(wr_valid_o && wr_byte_o == prev_byte, "R5 byte held under stall",
                    int'(wr_byte_o), int'(prev_byte));
            rdy = wr_valid_o && (stall_cnt >= stall_len);
            if (rdy) begin
                if (log_cnt < 64) begin
                    log_b[log_cnt] = wr_byte_o;
                    log_c[log_cnt] = wr_cmd_o;
                    log_t[log_cnt] = cyc;
                end
                log_cnt++;
                stall_cnt = 0;
            end else if (wr_valid_o) stall_cnt++;
            prev_stall = wr_valid_o && !rdy;
            prev_byte  = wr_byte_o;
            wr_ready_i = rdy;
            if (panel_rst_n_o && !rst_seen) begin rst_seen = 1; rst_rise = cyc; end
            if (hv_en_o && !hv_prev) hv_rise = cyc;
            if (!hv_en_o && hv_prev) hv_fall = cyc;
            hv_prev = hv_en_o;
            if (refresh_req_o && !refresh_ack_i) begin
                rq_cnt++;
                if (rq_cnt == 3) begin
                    chk(!done_o, "R7 done before ack", int'(done_o), 0);
                    refresh_ack_i = 1;
                    ref_count++;
                end
            end else begin
                refresh_ack_i = 0;
                if (!refresh_req_o) rq_cnt = 0;
            end
        end
    end

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) start_i = 1; else if (which == 1) sleep_req_i = 1;
        else wake_req_i = 1;
        @(negedge clk);
        start_i = 0; sleep_req_i = 0; wake_req_i = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) begin
            int start_cyc;
            rst_n = 0;
            stall_len = s; stall_cnt = 0; log_cnt = 0; prev_stall = 0; rst_seen = 0;
            hv_prev = 0; rq_cnt = 0; ref_count = 0; refresh_ack_i = 0; wr_ready_i = 0;
            rst_rise = 0; hv_rise = 0; hv_fall = 0;
            repeat (3) @(negedge clk);
            // R1 reset state
            chk(!panel_rst_n_o && !hv_en_o && !wr_valid_o && !busy_o && !done_o,
                "R1 reset outputs", {panel_rst_n_o, hv_en_o, wr_valid_o, busy_o, done_o}, 0);
            rst_n = 1;
            pulse(1); pulse(2); repeat (3) @(negedge clk);
            chk(!busy_o && !hv_en_o && log_cnt == 0, "R10 requests ignored in idle",
                int'(busy_o) + int'(hv_en_o), 0);
            @(negedge clk); start_cyc = cyc; start_i = 1;
            @(negedge clk); start_i = 0;
            repeat (20) @(negedge clk);
            chk(!panel_rst_n_o && log_cnt == 0, "R2 reset held early", int'(panel_rst_n_o), 0);
            pulse(1); pulse(2); pulse(0);
            for (int k = 0; k < 5000 && !done_o; k++) @(negedge clk);
            repeat (2) @(negedge clk);
            chk(rst_rise - start_cyc >= HOLD * MS && rst_rise - start_cyc <= HOLD * MS + 4,
                "R2 reset hold length", rst_rise - start_cyc, HOLD * MS + 2);
            chk(log_t[0] - rst_rise >= RECOV * MS && log_t[0] - rst_rise <= RECOV * MS + 4 + s,
                "R3 recovery wait", log_t[0] - rst_rise, RECOV * MS + 1);
            chk(log_cnt == 26, "R10 byte count after init with ignored requests", log_cnt, 26);
            for (int i = 0; i < 25; i++)
                chk(log_b[i] == exp_tab[i] && log_c[i], "R4 table byte",
                    int'(log_b[i]), int'(exp_tab[i]));
            chk(log_b[25] == 8'hAF && log_c[25], "R6 display-on byte", int'(log_b[25]), 'hAF);
            chk(log_t[25] - hv_rise >= HV * MS && log_t[25] - hv_rise <= HV * MS + 8,
                "R6 high-voltage settle", log_t[25] - hv_rise, HV * MS + 1);
            chk(ref_count == 1 && done_o && !busy_o, "R7 refresh and done", ref_count, 1);
            pulse(0); repeat (10) @(negedge clk);
            chk(log_cnt == 26 && panel_rst_n_o && !busy_o, "R10 start after done ignored",
                log_cnt, 26);
            // Sleep
            pulse(1);
            for (int k = 0; k < 2000 && hv_en_o; k++) @(negedge clk);
            repeat (2) @(negedge clk);
            chk(log_cnt == 27 && log_b[26] == 8'hAE, "R8 display-off byte",
                int'(log_b[26]), 'hAE);
            chk(hv_fall - log_t[26] >= SLP * MS && hv_fall - log_t[26] <= SLP * MS + 8,
                "R8 sleep wait", hv_fall - log_t[26], SLP * MS + 2);
            chk(!busy_o && done_o && !hv_en_o, "R8 asleep state", int'(hv_en_o), 0);
            // Wake
            pulse(2);
            for (int k = 0; k < 2000 && (busy_o || !hv_en_o); k++) @(negedge clk);
            repeat (8) @(negedge clk);
            chk(log_cnt == 28 && log_b[27] == 8'hAF, "R9 wake display-on", int'(log_b[27]), 'hAF);
            chk(log_t[27] - hv_rise >= HV * MS && log_t[27] - hv_rise <= HV * MS + 8,
                "R9 wake settle", log_t[27] - hv_rise, HV * MS + 1);
            chk(ref_count == 1 && hv_en_o && !busy_o, "R9 no refresh on wake", ref_count, 1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule